// File: doc/BRIEF.md
# Phase-Window Lock Detector

This block tells a loop controller whether a feedback clock has settled into phase alignment with a reference clock. Both clocks are sampled by a much faster oversampling clock. Delay lines built from shift registers of fast-clock ticks stand in for analog delay cells. A window of `T` ticks is taken from `win_ticks` at reset.

On every feedback rising edge, a first comparison samples the reference delayed by `T`. This comparison trips when the reference leads by `T` ticks or more. A second comparison takes the reference at the same `T` delay, but samples it on the feedback edge delayed by `2T`. This one trips when the reference lags by more than `T`.

Both comparisons are combined once per feedback edge into one in-window result. Lock is reported only after `N_HITS` in-window results in a row. A single out-of-window result drops the lock flag at once.

Top module: `phase_window_lockdet`

## Requirements
- R1: While `rst` is high, and after it falls, `lock_n` is 1 until the comparisons report lock.
- R2: The offset is the feedback rising-edge tick minus the reference rising-edge tick, so a positive offset means the reference leads. An offset of `T` or more is out of window, and `lock_n` stays 1.
- R3: An offset below `-T` (reference lagging by more than `T`) is out of window, and `lock_n` stays 1.
- R4: An offset in the range `-T <= offset < T`, repeated on every feedback edge, drives `lock_n` to 0.
- R5: After an out-of-window result, `lock_n` goes to 0 only on the `N_HITS`-th consecutive in-window result (default 4). After `N_HITS-1` such results it is still 1.
- R6: One out-of-window result sets `lock_n` to 1 within two fast-clock ticks of the delayed feedback edge.
- R7: `T` is captured only while `rst` is high. Changes on `win_ticks` after reset have no effect on the window.
- R8: A captured `win_ticks` of 0 acts as `T = 1`. A value above `MAX_T` (default 16) acts as `T = MAX_T`.
- R9: A new reset with a different `win_ticks` moves both window edges to the new `T`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset; also loads the window width |
| ref_in | input | 1 | Reference clock, sampled on `clk` |
| fb_in | input | 1 | Feedback (divided oscillator) clock, sampled on `clk` |
| win_ticks | input | $clog2(MAX_T+1) | Window width `T` in `clk` ticks, captured during reset |
| lock_n | output | 1 | Active-low lock flag |

## Verification
A wrong tap index on either delay line would shift one window edge by whole ticks. It would show as a wrong `lock_n` value on the offset sweep at exactly `±T`, one feedback period after the offset settles.

A hit counter that fails to clear, or that saturates at the wrong value, would show as `lock_n` falling one feedback period too early or too late after a miss. A window register that follows `win_ticks` outside reset would make offsets between the old and new `T` report the wrong state within a few feedback periods.

// File: rtl/phase_window_lockdet.sv
module phase_window_lockdet #(
  parameter int MAX_T  = 16,
  parameter int N_HITS = 4,
  localparam int TW = $clog2(MAX_T + 1),
  localparam int CW = $clog2(N_HITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic [TW-1:0] win_ticks,
  output logic          lock_n
);

  logic [TW-1:0]      t_q;
  logic [MAX_T:0]     ref_sr;
  logic [2*MAX_T+1:0] fb_sr;
  logic               lead_q;
  logic [CW-1:0]      hits;
  logic [TW-1:0]      t_load;

  always_comb begin
    if (win_ticks == '0)                   t_load = TW'(1);
    else if (win_ticks > TW'(MAX_T))       t_load = TW'(MAX_T);
    else                                   t_load = win_ticks;
  end

  wire ref_tap = ref_sr[t_q];
  wire ev_now  = fb_sr[0] & ~fb_sr[1];
  wire ev_late = fb_sr[{t_q, 1'b0}] & ~fb_sr[{t_q, 1'b1}];
  wire inwin   = ~lead_q & ref_tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= t_load;
      ref_sr <= '0;
      fb_sr  <= '0;
      lead_q <= 1'b0;
      hits   <= '0;
      lock_n <= 1'b1;
    end else begin
      ref_sr <= {ref_sr[MAX_T-1:0], ref_in};
      fb_sr  <= {fb_sr[2*MAX_T:0], fb_in};
      if (ev_now) lead_q <= ref_tap;
      if (ev_late) begin
        if (inwin) begin
          if (hits != CW'(N_HITS)) hits <= hits + 1'b1;
          lock_n <= !(hits >= CW'(N_HITS - 1));
        end else begin
          hits   <= '0;
          lock_n <= 1'b1;
        end
      end
    end
  end

  // R1
  reset_flag_chk: assert property (@(posedge clk) rst |=> lock_n);

  // R6
  miss_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_late && !inwin) |=> lock_n);

  // R4
  lock_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n) |-> $past(ev_late && inwin));

  // R5
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_late |=> $stable(lock_n));

  // R7
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(t_q));

  // R8
  window_range_chk: assert property (@(posedge clk) disable iff (rst)
    (t_q >= TW'(1)) && (t_q <= TW'(MAX_T)));

  // R5
  hit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hits <= CW'(N_HITS));

endmodule

// File: tb/sim_phase_window_lockdet.sv
module sim_phase_window_lockdet;
  localparam int MAX_T = 16;
  localparam int TW = $clog2(MAX_T + 1);
  localparam int P = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic [TW-1:0] win_ticks = TW'(4);
  logic lock_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic exp_q[$];
  string tag_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  phase_window_lockdet #(.MAX_T(MAX_T), .N_HITS(4)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .win_ticks(win_ticks), .lock_n(lock_n));

  function automatic logic hi_at(int k, int off);
    int m;
    m = ((k - 16 - off) % P + P) % P;
    return m < P / 2;
  endfunction

  task automatic run(int off, int n);
    for (int p = 0; p < n; p++)
      for (int k = 0; k < P; k++) begin
        @(negedge clk);
        ref_in = hi_at(k, 0);
        fb_in  = hi_at(k, off);
      end
  endtask

  task automatic expect_flag(logic e, string r);
    exp_q.push_back(e);
    tag_q.push_back(r);
    ->chk_ev;
    #1;
  endtask

  task automatic do_reset(int t);
    rst = 1'b1;
    ref_in = 1'b0;
    fb_in = 1'b0;
    win_ticks = TW'(t);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sweep(int t);
    for (int off = -3 * t; off <= 3 * t; off++) begin
      run(off, 6);
      if (off >= t)       expect_flag(1'b1, "R2");
      else if (off < -t)  expect_flag(1'b1, "R3");
      else                expect_flag(1'b0, "R4");
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      begin
        logic e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        total++;
        if (lock_n !== e) begin
          bad++;
          $display("FAIL %s: lock_n=%b expected=%b at %0t", r, lock_n, e, $time);
        end
      end
    end
  end

  initial begin
    do_reset(4);
    @(negedge clk);
    expect_flag(1'b1, "R1");
    sweep(4);
    run(0, 3);
    expect_flag(1'b1, "R5");
    run(0, 1);
    expect_flag(1'b0, "R5");
    run(8, 1);
    expect_flag(1'b1, "R6");
    run(0, 3);
    expect_flag(1'b1, "R5");
    run(0, 1);
    expect_flag(1'b0, "R5");
    win_ticks = TW'(1);
    run(2, 5);
    expect_flag(1'b0, "R7");
    run(-3, 5);
    expect_flag(1'b0, "R7");
    do_reset(0);
    run(0, 5);
    expect_flag(1'b0, "R8");
    run(1, 5);
    expect_flag(1'b1, "R8");
    run(-1, 5);
    expect_flag(1'b0, "R8");
    run(-2, 5);
    expect_flag(1'b1, "R8");
    do_reset(31);
    run(15, 5);
    expect_flag(1'b0, "R8");
    run(16, 5);
    expect_flag(1'b1, "R8");
    run(-16, 5);
    expect_flag(1'b0, "R8");
    do_reset(2);
    sweep(2);
    run(2, 5);
    expect_flag(1'b1, "R9");
    run(-2, 5);
    expect_flag(1'b0, "R9");
    #5;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule